// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block remembers the stores issued inside the current dispatch group and tells the issue logic when a later load would touch bytes one of those stores wrote. Each store is recorded as a base identifier, a signed byte offset from that base and an access size in bytes. A load query presents the same three fields. When the load overlaps a recorded store, the block raises a combinational conflict flag in the same cycle. The issue logic answers the flag by inserting a no-op, so the load moves into a later group.

Storage is small and fixed at four entries per group. Stores beyond that are dropped without notice. A group-clear input empties the table when the dispatch group closes. Two accesses can only collide when their base identifiers match. Offsets are compared as two's-complement values with one extra bit of headroom, so no end address wraps.

Top module: `stld_overlap_guard`

## Requirements
- R1: After a synchronous active-high reset, `st_count` is 0 and `conflict` is 0.
- R2: A store strobe (`st_valid`=1, `grp_clear`=0) while fewer than 4 entries are held records the store, and `st_count` is one higher from the next cycle on.
- R3: A store arriving while 4 entries are held is not recorded: `st_count` stays 4, and a later load matching only that store raises no conflict.
- R4: A load whose base and offset both equal those of a held store raises `conflict`.
- R5: With equal bases and store offset below load offset (signed 16-bit), `conflict` is 1 exactly when store offset + store size (unsigned 8-bit) is greater than load offset. The sum is computed without wrap.
- R6: With equal bases and store offset not below load offset, `conflict` is 1 exactly when load offset + load size is greater than store offset. The sum is computed without wrap.
- R7: A held store with a different base identifier never causes a conflict.
- R8: `conflict` is 0 whenever `ld_valid` is 0 or no store is held.
- R9: `grp_clear`=1 empties the table, so `st_count` is 0 in the next cycle. A store strobed in the same cycle is discarded.
- R10: A load is compared only against stores recorded in earlier cycles. A store strobed in the same cycle as the load is not seen by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Record a store this cycle |
| st_base | input | BASE_W | Store base identifier |
| st_off | input | OFF_W | Store signed offset |
| st_size | input | SIZE_W | Store size in bytes |
| ld_valid | input | 1 | A load query is present |
| ld_base | input | BASE_W | Load base identifier |
| ld_off | input | OFF_W | Load signed offset |
| ld_size | input | SIZE_W | Load size in bytes |
| grp_clear | input | 1 | Dispatch group ends: empty the table |
| conflict | output | 1 | Load overlaps a held store (combinational) |
| st_count | output | CNT_W | Number of held stores |

## Verification
The overlap rule is tested at both sides of each boundary. For a store below the load, an end exactly at the load offset must report no conflict, while an end one byte past it must report one. For a store at or above the load, the check is mirrored on the load side. Offsets at the extremes of the signed 16-bit range show that the comparison does not wrap. Further patterns separate the base-identifier gate, the `ld_valid` gate, the fifth store that is dropped, same-cycle visibility of a new store, and a clear that arrives together with a store.

// File: rtl/stld_pkg.sv
package stld_pkg;
  localparam int DEF_BASE_W = 8;
  localparam int DEF_OFF_W  = 16;
  localparam int DEF_SIZE_W = 8;
  localparam int DEF_DEPTH  = 4;
endpackage

// File: rtl/stld_entry_file.sv
module stld_entry_file #(
  parameter int BASE_W = stld_pkg::DEF_BASE_W,
  parameter int OFF_W  = stld_pkg::DEF_OFF_W,
  parameter int SIZE_W = stld_pkg::DEF_SIZE_W,
  parameter int DEPTH  = stld_pkg::DEF_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_req,
  input  logic                          clr,
  input  logic [BASE_W-1:0]             wr_base,
  input  logic [OFF_W-1:0]              wr_off,
  input  logic [SIZE_W-1:0]             wr_size,
  output logic [DEPTH-1:0][BASE_W-1:0]  rd_base,
  output logic [DEPTH-1:0][OFF_W-1:0]   rd_off,
  output logic [DEPTH-1:0][SIZE_W-1:0]  rd_size,
  output logic [DEPTH-1:0]              rd_live,
  output logic [CNT_W-1:0]              count
);
  logic [BASE_W-1:0] mem_base [DEPTH];
  logic [OFF_W-1:0]  mem_off  [DEPTH];
  logic [SIZE_W-1:0] mem_size [DEPTH];
  logic              room;
  logic              do_wr;

  assign room  = (count < CNT_W'(DEPTH));
  assign do_wr = wr_req && !clr && room;

  // Storage without reset so it maps onto plain RAM bits
  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem_base[IDX_W'(count)] <= wr_base;
      mem_off[IDX_W'(count)]  <= wr_off;
      mem_size[IDX_W'(count)] <= wr_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (do_wr)
      count <= count + CNT_W'(1);
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rd
      assign rd_base[i] = mem_base[i];
      assign rd_off[i]  = mem_off[i];
      assign rd_size[i] = mem_size[i];
      assign rd_live[i] = (CNT_W'(i) < count);
    end
  endgenerate

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_req && !clr) |=> $stable(count));
endmodule

// File: rtl/stld_range_cmp.sv
module stld_range_cmp #(
  parameter int BASE_W = stld_pkg::DEF_BASE_W,
  parameter int OFF_W  = stld_pkg::DEF_OFF_W,
  parameter int SIZE_W = stld_pkg::DEF_SIZE_W,
  localparam int SUM_W = OFF_W + 1
) (
  input  logic              en,
  input  logic [BASE_W-1:0] s_base,
  input  logic [OFF_W-1:0]  s_off,
  input  logic [SIZE_W-1:0] s_size,
  input  logic [BASE_W-1:0] l_base,
  input  logic [OFF_W-1:0]  l_off,
  input  logic [SIZE_W-1:0] l_size,
  output logic              hit
);
  logic signed [SUM_W-1:0] so, lo, s_end, l_end;
  logic                    same_base, below, ovl;

  always_comb begin
    so        = {s_off[OFF_W-1], s_off};
    lo        = {l_off[OFF_W-1], l_off};
    s_end     = so + $signed({{(SUM_W-SIZE_W){1'b0}}, s_size});
    l_end     = lo + $signed({{(SUM_W-SIZE_W){1'b0}}, l_size});
    same_base = (s_base == l_base);
    below     = (so < lo);
    if (so == lo)
      ovl = 1'b1;
    else if (below)
      ovl = (s_end > lo);
    else
      ovl = (l_end > so);
    hit = en && same_base && ovl;
  end
endmodule

// File: rtl/stld_overlap_guard.sv
module stld_overlap_guard #(
  parameter int BASE_W = stld_pkg::DEF_BASE_W,
  parameter int OFF_W  = stld_pkg::DEF_OFF_W,
  parameter int SIZE_W = stld_pkg::DEF_SIZE_W,
  parameter int DEPTH  = stld_pkg::DEF_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [BASE_W-1:0] st_base,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              ld_valid,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              grp_clear,
  output logic              conflict,
  output logic [CNT_W-1:0]  st_count
);
  logic [DEPTH-1:0][BASE_W-1:0] e_base;
  logic [DEPTH-1:0][OFF_W-1:0]  e_off;
  logic [DEPTH-1:0][SIZE_W-1:0] e_size;
  logic [DEPTH-1:0]             e_live;
  logic [DEPTH-1:0]             e_hit;

  stld_entry_file #(
    .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
  ) u_file (
    .clk(clk), .rst(rst), .wr_req(st_valid), .clr(grp_clear),
    .wr_base(st_base), .wr_off(st_off), .wr_size(st_size),
    .rd_base(e_base), .rd_off(e_off), .rd_size(e_size),
    .rd_live(e_live), .count(st_count)
  );

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      stld_range_cmp #(
        .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
      ) u_cmp (
        .en(ld_valid && e_live[i]),
        .s_base(e_base[i]), .s_off(e_off[i]), .s_size(e_size[i]),
        .l_base(ld_base), .l_off(ld_off), .l_size(ld_size),
        .hit(e_hit[i])
      );
    end
  endgenerate

  assign conflict = |e_hit;

  // R8
  conf_gate_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (ld_valid && st_count != '0));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    st_count <= CNT_W'(DEPTH));
  // R9
  grp_clr_chk: assert property (@(posedge clk) disable iff (rst)
    grp_clear |=> (st_count == '0));
  // R2
  st_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !grp_clear && st_count < CNT_W'(DEPTH))
      |=> (st_count == $past(st_count) + CNT_W'(1)));
endmodule

// File: tb/stld_overlap_guard_bench.sv
module stld_overlap_guard_bench;
  localparam int BW = 8, OW = 16, SW = 8, DP = 4, CW = 3;

  logic clk = 0, rst = 1;
  logic st_valid = 0, ld_valid = 0, grp_clear = 0;
  logic [BW-1:0] st_base = 0, ld_base = 0;
  logic [OW-1:0] st_off = 0, ld_off = 0;
  logic [SW-1:0] st_size = 0, ld_size = 0;
  logic conflict;
  logic [CW-1:0] st_count;

  int checks = 0, fails = 0;
  bit done = 0;

  stld_overlap_guard u_stld_overlap_guard (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_base(st_base),
    .st_off(st_off), .st_size(st_size), .ld_valid(ld_valid),
    .ld_base(ld_base), .ld_off(ld_off), .ld_size(ld_size),
    .grp_clear(grp_clear), .conflict(conflict), .st_count(st_count)
  );

  always #10 clk = ~clk;

  // reference table
  int mb[DP], mo[DP], ms[DP];
  int mcnt = 0;

  bit      q_conf[$];
  int      q_cnt[$];
  string   q_tag[$];

  function automatic bit ref_conf(bit lv, int b, int o, int s);
    bit r = 0;
    if (!lv) return 0;
    for (int i = 0; i < mcnt; i++) begin
      if (mb[i] == b) begin
        if (mo[i] == o) r = 1;
        else if (mo[i] < o) begin if (mo[i] + ms[i] > o) r = 1; end
        else begin if (o + s > mo[i]) r = 1; end
      end
    end
    return r;
  endfunction

  task automatic op(string tag, bit sv, int sb, int so, int ss,
                    bit lv, int lb, int lo, int ls, bit clr);
    @(posedge clk); #1;
    st_valid = sv; st_base = BW'(sb); st_off = OW'(so); st_size = SW'(ss);
    ld_valid = lv; ld_base = BW'(lb); ld_off = OW'(lo); ld_size = SW'(ls);
    grp_clear = clr;
    q_conf.push_back(ref_conf(lv, lb, lo, ls));
    q_cnt.push_back(mcnt);
    q_tag.push_back(tag);
    if (clr) mcnt = 0;
    else if (sv && mcnt < DP) begin
      mb[mcnt] = sb; mo[mcnt] = so; ms[mcnt] = ss; mcnt++;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_tag.size() != 0) begin
      bit ec; int en; string t;
      ec = q_conf.pop_front(); en = q_cnt.pop_front(); t = q_tag.pop_front();
      checks++;
      if (conflict !== ec || int'(st_count) != en) begin
        fails++;
        $display("FAIL %s: conflict=%0d count=%0d expected conflict=%0d count=%0d",
                 t, conflict, st_count, ec, en);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    op("R1 idle after reset",        0,0,0,0, 0,0,0,0, 0);
    op("R8 load with empty table",   0,0,0,0, 1,1,0,4, 0);
    op("R10 same-cycle store",       1,1,0,4, 1,1,0,1, 0);
    op("R4 equal base/offset",       0,0,0,0, 1,1,0,1, 0);
    op("R5 store below, overlap",    0,0,0,0, 1,1,3,2, 0);
    op("R5 store end at load off",   0,0,0,0, 1,1,4,2, 0);
    op("R6 load end at store off",   0,0,0,0, 1,1,-2,2, 0);
    op("R6 load end past store off", 0,0,0,0, 1,1,-2,3, 0);
    op("R7 different base",          0,0,0,0, 1,2,0,4, 0);
    op("R8 ld_valid low",            0,0,0,0, 0,1,0,4, 0);
    op("R2 store min offset",        1,3,-32768,255, 0,0,0,0, 0);
    op("R2 store max offset",        1,3,32767,255,  0,0,0,0, 0);
    op("R2 fourth store",            1,4,100,8, 0,0,0,0, 0);
    op("R4 max offset match",        0,0,0,0, 1,3,32767,1, 0);
    op("R5 no wrap low end",         0,0,0,0, 1,3,-32600,1, 0);
    op("R6 no wrap high end",        0,0,0,0, 1,3,32766,1, 0);
    op("R5 store below, miss",       0,0,0,0, 1,4,108,4, 0);
    op("R3 fifth store dropped",     1,5,0,4, 0,0,0,0, 0);
    op("R3 dropped store no conflict", 0,0,0,0, 1,5,0,4, 0);
    op("R9 clear with store",        1,6,0,4, 0,0,0,0, 1);
    op("R9 empty after clear",       0,0,0,0, 1,6,0,4, 0);
    op("R9 old entry gone",          0,0,0,0, 1,1,0,4, 0);
    op("R2 store after clear",       1,7,10,2, 0,0,0,0, 0);
    op("R6 store above, overlap",    0,0,0,0, 1,7,8,3, 0);
    op("R9 clear idle",              0,0,0,0, 0,0,0,0, 1);
    op("R1 count zero again",        0,0,0,0, 0,0,0,0, 0);
    @(posedge clk); #1;
    st_valid = 0; ld_valid = 0; grp_clear = 0;
    while (q_tag.size() != 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule